// File: doc/BRIEF.md
# DMA Control-Port Register and Request Arbiter

This block is the control side of a four-channel DMA controller. It owns the command register, a four-bit channel mask, an eight-bit status register and one mode byte per channel. The status register keeps the terminal-count flags in bits 3:0 and the pending-request flags in bits 7:4. A host writes eight control offsets and reads two. Peripheral hardware raises and drops requests through per-channel hold and release inputs. Each cycle the block registers a one-hot grant for the lowest-numbered channel that is unmasked and requesting.

The address and count registers sit in a neighbouring block. This block only gives that neighbour a strobe that clears its byte-pointer flip-flop. The transfer engine reads the grant and the per-channel mode bytes. It pulses a terminal-count input when the granted channel finishes. Page registers and bus cycles are handled outside this block.

Top module: `dma_ctl_core`

## Requirements
- R1: After reset the mask reads 4'hF, status, command and every mode byte are zero, and the grant is zero.
- R2: A write to offset 0 loads the command register only when the data is 8'h00 or 8'h04; any other value leaves the command unchanged. Command bit 2 disables the controller.
- R3: A write to offset 1 selects a channel with data bits 1:0. It sets that channel's request bit (status bit channel+4) when data bit 2 is 1 and clears it when data bit 2 is 0. It always clears that channel's terminal-count bit (status bit channel).
- R4: A write to offset 2 sets the mask bit of the channel in data bits 1:0 when data bit 2 is 1 and clears it when data bit 2 is 0.
- R5: A write to offset 3 stores the whole data byte as the mode of the channel in data bits 1:0. The mode of channel i appears on `mode_o[8i+7:8i]`.
- R6: `ff_clr` is high, combinationally, in any cycle that writes offset 4 or offset 5.
- R7: A write to offset 5 sets all mask bits and zeroes status and command. It overrides every other status update in the same cycle.
- R8: A write to offset 6 clears all mask bits. A write to offset 7 loads the mask from data bits 3:0.
- R9: `rdata` is combinational. Reading offset 0 returns the status byte, and the read clears status bits 3:0 at the clock edge. Offset 1 returns {4'h0, mask}. Every other offset returns 8'h00.
- R10: `hold_req[i]` sets request bit i+4 and `rel_req[i]` clears it. When several updates fall in one cycle they apply in this order: read-clear, software request, hold, release, terminal count. A later update wins.
- R11: `grant` is registered and one-hot. It names the lowest-indexed channel whose mask bit is 0 and whose request bit is 1, judged on the state before the edge. It is zero when no channel qualifies or when command bit 2 is set.
- R12: `tc_in` while `grant[i]` is high sets status bit i and clears request bit i+4 at the edge. This set wins over a status read-clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control write strobe |
| rd_en | input | 1 | Control read strobe |
| addr | input | 3 | Control offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| hold_req | input | 4 | Per-channel hardware request set |
| rel_req | input | 4 | Per-channel hardware request release |
| tc_in | input | 1 | Terminal count for the granted channel |
| grant | output | 4 | Registered one-hot service grant |
| ff_clr | output | 1 | Byte-pointer flip-flop clear strobe |
| cmd_o | output | 8 | Command register |
| mode_o | output | 32 | Four mode bytes, channel 0 in the low byte |

## Verification
`rdata` and `ff_clr` are combinational, so the bench checks them one time unit after it drives the inputs, before the clock edge. Register writes, status updates and the grant all take effect at the next rising edge. The bench checks them at the following falling edge against a model that steps once per edge. The grant is computed from the state before the edge, so the model derives its expected grant from its own pre-update state. That is why a newly raised request shows up as a grant one cycle after it appears in the status read.

// File: rtl/dma_ctl_pkg.sv
// Package: shared sizes and control offsets for the DMA control-port block.
// Assumes four channels and byte-wide host data.
package dma_ctl_pkg;
    localparam int CH_N   = 4;
    localparam int DATA_W = 8;
    localparam int OFS_W  = 3;
    localparam int SEL_W  = $clog2(CH_N);

    typedef enum logic [OFS_W-1:0] {
        OFS_CMD     = 3'd0,
        OFS_SWREQ   = 3'd1,
        OFS_MASK1   = 3'd2,
        OFS_MODE    = 3'd3,
        OFS_FFCLR   = 3'd4,
        OFS_MRESET  = 3'd5,
        OFS_MASKCLR = 3'd6,
        OFS_MASKALL = 3'd7
    } ofs_e;

    localparam logic [DATA_W-1:0] CMD_ALLOWED = 8'h04;
    localparam int CMD_DIS_BIT = 2;
endpackage

// File: rtl/dma_ctl_regs.sv
// Module: command, mask and per-channel mode registers.
// Assumes the write strobe and offset are valid for one cycle per access.
module dma_ctl_regs
    import dma_ctl_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [OFS_W-1:0]        addr,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       cmd_q,
    output logic [CH_N-1:0]         mask_q,
    output logic [CH_N*DATA_W-1:0]  mode_q
);
    logic [SEL_W-1:0] sel;
    logic             cmd_ok;

    // channel select and command legality from the write data
    always_comb begin
        sel    = wdata[SEL_W-1:0];
        cmd_ok = (wdata & ~CMD_ALLOWED) == '0;
    end

    // command register: only legal values are taken
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= '0;
        else if (wr_en && addr == OFS_MRESET)
            cmd_q <= '0;
        else if (wr_en && addr == OFS_CMD && cmd_ok)
            cmd_q <= wdata;
    end

    // mask register: single, clear-all, load-all and master-reset writes
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '1;
        else if (wr_en) begin
            case (addr)
                OFS_MASK1:   mask_q[sel] <= wdata[2];
                OFS_MRESET:  mask_q <= '1;
                OFS_MASKCLR: mask_q <= '0;
                OFS_MASKALL: mask_q <= wdata[CH_N-1:0];
                default:     mask_q <= mask_q;
            endcase
        end
    end

    // one mode byte per channel
    for (genvar gi = 0; gi < CH_N; gi++) begin : g_mode
        always_ff @(posedge clk) begin
            if (!rst_n)
                mode_q[gi*DATA_W +: DATA_W] <= '0;
            else if (wr_en && addr == OFS_MODE && sel == SEL_W'(gi))
                mode_q[gi*DATA_W +: DATA_W] <= wdata;
        end
    end
endmodule

// File: rtl/dma_ctl_status.sv
// Module: status register (terminal-count flags low, request flags high).
// Assumes the grant is one-hot; updates apply in a fixed order per cycle.
module dma_ctl_status
    import dma_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [OFS_W-1:0]  addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CH_N-1:0]   hold_req,
    input  logic [CH_N-1:0]   rel_req,
    input  logic              tc_in,
    input  logic [CH_N-1:0]   grant,
    output logic [2*CH_N-1:0] status_q
);
    logic [2*CH_N-1:0] nxt;
    logic [SEL_W-1:0]  sel;

    // ordered next-state: read-clear, software request, hold, release, tc
    always_comb begin
        sel = wdata[SEL_W-1:0];
        nxt = status_q;
        if (rd_en && addr == OFS_CMD)
            nxt[CH_N-1:0] = '0;
        if (wr_en && addr == OFS_SWREQ) begin
            nxt[CH_N + int'(sel)] = wdata[2];
            nxt[int'(sel)]        = 1'b0;
        end
        nxt[2*CH_N-1:CH_N] = nxt[2*CH_N-1:CH_N] | hold_req;
        nxt[2*CH_N-1:CH_N] = nxt[2*CH_N-1:CH_N] & ~rel_req;
        for (int i = 0; i < CH_N; i++) begin
            if (tc_in && grant[i]) begin
                nxt[i]        = 1'b1;
                nxt[CH_N + i] = 1'b0;
            end
        end
        if (wr_en && addr == OFS_MRESET)
            nxt = '0;
    end

    // status register update
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= nxt;
    end
endmodule

// File: rtl/dma_ctl_arb.sv
// Module: fixed-priority grant, channel 0 highest.
// Assumes request and mask come from registers; the grant is registered.
module dma_ctl_arb
    import dma_ctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CH_N-1:0] req,
    input  logic [CH_N-1:0] mask,
    input  logic            dis,
    output logic [CH_N-1:0] grant
);
    logic [CH_N-1:0] elig;
    logic [CH_N-1:0] pick;
    logic [CH_N:0]   taken;

    // eligible channels
    assign elig     = req & ~mask & {CH_N{~dis}};
    assign taken[0] = 1'b0;

    // priority chain from the lowest index up
    for (genvar gi = 0; gi < CH_N; gi++) begin : g_pri
        assign pick[gi]      = elig[gi] & ~taken[gi];
        assign taken[gi + 1] = taken[gi] | elig[gi];
    end

    // grant register
    always_ff @(posedge clk) begin
        if (!rst_n) grant <= '0;
        else        grant <= pick;
    end
endmodule

// File: rtl/dma_ctl_core.sv
// Module: top of the DMA control-port block: registers, status and grant.
// Assumes the host bus is synchronous; reads have no wait states.
module dma_ctl_core
    import dma_ctl_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic [2:0]   addr,
    input  logic [7:0]   wdata,
    output logic [7:0]   rdata,
    input  logic [3:0]   hold_req,
    input  logic [3:0]   rel_req,
    input  logic         tc_in,
    output logic [3:0]   grant,
    output logic         ff_clr,
    output logic [7:0]   cmd_o,
    output logic [31:0]  mode_o
);
    logic [DATA_W-1:0]  cmd_q;
    logic [CH_N-1:0]    mask_q;
    logic [2*CH_N-1:0]  status_q;

    dma_ctl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .cmd_q(cmd_q), .mask_q(mask_q), .mode_q(mode_o)
    );

    dma_ctl_status u_status (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .hold_req(hold_req), .rel_req(rel_req), .tc_in(tc_in),
        .grant(grant), .status_q(status_q)
    );

    dma_ctl_arb u_arb (
        .clk(clk), .rst_n(rst_n), .req(status_q[2*CH_N-1:CH_N]),
        .mask(mask_q), .dis(cmd_q[CMD_DIS_BIT]), .grant(grant)
    );

    // read-data mux and flip-flop clear strobe
    always_comb begin
        case (addr)
            OFS_CMD:   rdata = status_q;
            OFS_SWREQ: rdata = {{(DATA_W-CH_N){1'b0}}, mask_q};
            default:   rdata = '0;
        endcase
        ff_clr = wr_en && (addr == OFS_FFCLR || addr == OFS_MRESET);
        cmd_o  = cmd_q;
    end
endmodule

// File: rtl/dma_ctl_chk.sv
// Module: assertion checker for dma_ctl_core, attached by bind.
// Assumes it sees the core's registered command, mask and status.
module dma_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic [2:0] addr,
    input logic [7:0] wdata,
    input logic       tc_in,
    input logic [3:0] grant,
    input logic [3:0] mask_q,
    input logic [7:0] status_q,
    input logic [7:0] cmd_q
);
    // R11
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R11
    grant_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != 4'h0) |-> (((grant & $past(~mask_q & status_q[7:4])) != 4'h0)
                             && !$past(cmd_q[2])));

    // R2
    cmd_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0 && wdata != 8'h00 && wdata != 8'h04)
        |=> $stable(cmd_q));

    // R7
    mreset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd5)
        |=> (mask_q == 4'hF && status_q == 8'h00 && cmd_q == 8'h00));

    // R9
    rdclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd0 && !(tc_in && grant != 4'h0)
         && !(wr_en && addr == 3'd1))
        |=> (status_q[3:0] == 4'h0));
endmodule

bind dma_ctl_core dma_ctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .tc_in(tc_in), .grant(grant), .mask_q(mask_q),
    .status_q(status_q), .cmd_q(cmd_q)
);

// File: tb/dma_ctl_core_test.sv
module dma_ctl_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, tc_in = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [3:0]  hold_req = '0, rel_req = '0;
    logic [7:0]  rdata;
    logic [3:0]  grant;
    logic        ff_clr;
    logic [7:0]  cmd_o;
    logic [31:0] mode_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // expected state
    logic [7:0]  m_cmd, m_status;
    logic [3:0]  m_mask, m_grant;
    logic [31:0] m_mode;

    dma_ctl_core uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .hold_req(hold_req), .rel_req(rel_req),
        .tc_in(tc_in), .grant(grant), .ff_clr(ff_clr), .cmd_o(cmd_o),
        .mode_o(mode_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R9 expected read data
    function automatic logic [7:0] exp_rdata(input logic [2:0] a);
        case (a)
            3'd0:    return m_status;
            3'd1:    return {4'h0, m_mask};
            default: return 8'h00;
        endcase
    endfunction

    // R11 expected grant from current model state
    function automatic logic [3:0] exp_grant();
        logic [3:0] e = m_status[7:4] & ~m_mask;
        if (m_cmd[2]) return 4'h0;
        for (int i = 0; i < 4; i++) if (e[i]) return 4'(1 << i);
        return 4'h0;
    endfunction

    // one bus cycle: drive, check combinational outputs, step model, check registers
    task automatic step(input logic w, input logic r, input logic [2:0] a,
                        input logic [7:0] d, input logic [3:0] h,
                        input logic [3:0] rl, input logic t);
        logic [7:0] s;
        logic [3:0] g_next;
        wr_en = w; rd_en = r; addr = a; wdata = d; hold_req = h; rel_req = rl; tc_in = t;
        #1;
        chk("R9 rdata", {24'h0, rdata}, {24'h0, exp_rdata(a)});
        chk("R6 ff_clr", {31'h0, ff_clr}, {31'h0, w && (a == 3'd4 || a == 3'd5)});
        @(posedge clk);
        g_next = exp_grant();
        s = m_status;
        if (r && a == 3'd0) s[3:0] = 4'h0;
        if (w && a == 3'd1) begin s[d[1:0] + 4] = d[2]; s[d[1:0]] = 1'b0; end
        s[7:4] = (s[7:4] | h) & ~rl;
        for (int i = 0; i < 4; i++)
            if (t && m_grant[i]) begin s[i] = 1'b1; s[i + 4] = 1'b0; end
        if (w) begin
            case (a)
                3'd0: if (d == 8'h00 || d == 8'h04) m_cmd = d;
                3'd2: m_mask[d[1:0]] = d[2];
                3'd3: m_mode[d[1:0]*8 +: 8] = d;
                3'd5: begin m_mask = 4'hF; m_cmd = 8'h00; s = 8'h00; end
                3'd6: m_mask = 4'h0;
                3'd7: m_mask = d[3:0];
                default: ;
            endcase
        end
        m_status = s;
        m_grant  = g_next;
        @(negedge clk);
        chk("R11 grant", {28'h0, grant}, {28'h0, m_grant});
        chk("R2 cmd", {24'h0, cmd_o}, {24'h0, m_cmd});
        chk("R5 mode", mode_o, m_mode);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_cmd = 0; m_status = 0; m_mask = 4'hF; m_grant = 0; m_mode = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        addr = 3'd1; #1;
        chk("R1 mask", {24'h0, rdata}, 32'h0F);
        addr = 3'd0; #1;
        chk("R1 status", {24'h0, rdata}, 32'h00);
        chk("R1 grant", {28'h0, grant}, 32'h0);
        chk("R1 cmd", {24'h0, cmd_o}, 32'h0);
        chk("R1 mode", mode_o, 32'h0);
        // R8 clear all masks, R3 software requests on channels 2 and 1
        step(1, 0, 3'd6, 8'h00, 0, 0, 0);
        step(1, 0, 3'd1, 8'h06, 0, 0, 0);
        step(1, 0, 3'd1, 8'h05, 0, 0, 0);
        step(0, 1, 3'd0, 8'h00, 0, 0, 0);   // R11 grant ch1 due now
        // R2 rejected command then accepted disable
        step(1, 0, 3'd0, 8'h01, 0, 0, 0);
        step(1, 0, 3'd0, 8'h04, 0, 0, 0);
        step(0, 0, 3'd0, 8'h00, 0, 0, 0);   // R11 grant off when disabled
        step(1, 0, 3'd0, 8'h00, 0, 0, 0);
        step(0, 0, 3'd0, 8'h00, 0, 0, 0);
        // R12 terminal count on granted channel with a read-clear in same cycle
        step(0, 1, 3'd0, 8'h00, 0, 0, 1);
        step(0, 1, 3'd0, 8'h00, 0, 0, 0);
        // R4 mask channel 2, R10 hold and release on channel 3
        step(1, 0, 3'd2, 8'h06, 4'h8, 0, 0);
        step(0, 1, 3'd0, 8'h00, 0, 4'h8, 0);
        // R5 mode bytes, R7 master reset, R8 load mask
        step(1, 0, 3'd3, 8'hA7, 0, 0, 0);
        step(1, 0, 3'd5, 8'h00, 4'hF, 0, 0);
        step(1, 0, 3'd7, 8'h5A, 0, 0, 0);
        step(0, 1, 3'd1, 8'h00, 0, 0, 0);
        step(1, 0, 3'd4, 8'h00, 0, 0, 0);   // R6 flip-flop clear strobe
        // random traffic covering R2..R12
        for (int k = 0; k < 3000; k++) begin
            logic w, r;
            logic [2:0] a;
            logic [7:0] d;
            w = ($urandom % 3) != 0;
            r = !w && ($urandom % 2);
            a = 3'($urandom);
            if (w && a == 3'd5 && ($urandom % 4) != 0) a = 3'd1;
            d = 8'($urandom);
            if (w && a == 3'd0 && ($urandom % 2)) d = ($urandom % 2) ? 8'h04 : 8'h00;
            step(w, r, a, d, 4'($urandom) & 4'($urandom), 4'($urandom) & 4'($urandom),
                 ($urandom % 3) == 0);
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule